// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Detection

This block turns an asynchronous serial line into parallel words. A free-running enable pulse at sixteen times the bit rate paces it. Clock division happens elsewhere. The divider upstream of the block has the form 16×(m+1), where m is an 8-bit value. Software picks the word length (7, 8 or 9 bits), the parity mode (none, even or odd) and the number of stop bits (1 or 2). The format is captured when a start bit is detected, so it stays constant for the whole frame.

The line passes through a synchronizer into a bit-timing state machine. The machine waits while reception is disabled. When the line falls it checks that the line is still low at the middle of the start bit, then samples every later bit at its middle. A finished word moves into a receive buffer register together with its parity and framing status, and a one-cycle interrupt pulse is raised. If the buffer still holds an unread word 6.5 bit times into the next frame, a sticky overrun flag is set. When that frame completes, its word replaces the buffer contents.

Top module: `uart_rx_ovr`

## Requirements
- R1: After reset, `rd_data_o` is 0 and `buf_full_o`, `par_err_o`, `frm_err_o`, `overrun_o` and `irq_o` are all 0.
- R2: `len_sel_i` selects the word length: 2'b00 gives 7 bits, 2'b01 gives 8 bits, 2'b10 and 2'b11 give 9 bits. Bits arrive LSB first and are right-aligned in `rd_data_o`. The bits above the word length read as 0.
- R3: `par_sel_i` selects parity: 2'b00 and 2'b01 mean no parity bit, 2'b10 means even, 2'b11 means odd. When the received parity bit disagrees with the selected mode over the data bits, `par_err_o` is 1 for that word; otherwise it is 0.
- R4: `stop2_i`=1 expects two stop bits and `stop2_i`=0 expects one. `frm_err_o` is 1 for a word exactly when its first stop bit was sampled low.
- R5: A falling line is taken as a start bit only if it is still low on the 8th tick. Otherwise the receiver goes back to idle and no word is delivered.
- R6: While `rx_en_i` is 0 nothing is received. Dropping `rx_en_i` in the middle of a frame abandons that frame without delivering a word.
- R7: `irq_o` pulses for one clock when a word is loaded into the buffer, and `buf_full_o` is 1 in that same cycle.
- R8: A `rd_i` pulse clears `buf_full_o`. If a load happens in the same cycle, the load wins.
- R9: At tick 104 (6.5 bit times) after start-bit detection, `overrun_o` is set if the buffer is full and not being read in that cycle. The new word still overwrites the buffer when its frame completes.
- R10: `overrun_o` stays set until an `ovr_clr_i` pulse clears it. Reading the buffer does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| rx_en_i | input | 1 | Receive enable |
| tick_i | input | 1 | Sampling pulse at 16x the bit rate |
| len_sel_i | input | 2 | Word length select |
| par_sel_i | input | 2 | Parity mode select |
| stop2_i | input | 1 | Two stop bits when 1 |
| rd_i | input | 1 | Buffer read strobe |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 9 | Receive buffer contents |
| buf_full_o | output | 1 | Buffer holds an unread word |
| par_err_o | output | 1 | Parity error of the buffered word |
| frm_err_o | output | 1 | Framing error of the buffered word |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | One-cycle receive interrupt |

## Verification
The overrun decision is tested on both sides of its fixed point. A buffer read six bit times into the following frame must suppress the flag, and a read at seven bit times must not. A design that checks at frame end, or that counts from the wrong edge, fails one of the two cases. Glitches that return high before the start-bit middle must deliver no word, which exposes receivers that trust the falling edge alone. Words sent with the 7-bit length and upper bits set, mismatched parity in both modes, and a low first stop bit with one and two stop bits catch alignment, parity-sense and stop-bit sequencing faults. Dropping the enable mid-frame and then sending a clean frame shows that an aborted frame leaves nothing behind.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_e;

  function automatic logic [3:0] word_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd7;
      2'b01:   return 4'd8;
      default: return 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '1;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              stop2_i,
  output logic              done_o,
  output logic              ovr_pt_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] word_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int PH_W     = $clog2(OSR) + 1;
  localparam int FRM_W    = $clog2(OSR * 16);
  localparam int HALF     = OSR / 2;
  localparam int OVR_TICK = OSR * 6 + OSR / 2;

  rx_state_e          state_q;
  logic [PH_W-1:0]    ph_q;
  logic [3:0]         bit_q;
  logic [DATA_W-1:0]  sh_q;
  logic [FRM_W-1:0]   frm_q;
  logic [1:0]         len_q;
  logic               par_en_q, par_odd_q, stop2_q, par_bit_q, ferr_q;

  logic [PH_W-1:0]  ph_nx;
  logic [FRM_W-1:0] frm_nx;
  logic [3:0]       len_w;
  logic             mid;

  assign ph_nx  = ph_q + 1'b1;
  assign frm_nx = frm_q + 1'b1;
  assign len_w  = word_len(len_q);
  assign mid    = (ph_nx == PH_W'(OSR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      ph_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      frm_q     <= '0;
      len_q     <= 2'b01;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      stop2_q   <= 1'b0;
      par_bit_q <= 1'b0;
      ferr_q    <= 1'b0;
      done_o    <= 1'b0;
      ovr_pt_o  <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      ovr_pt_o <= 1'b0;
      if (!en_i) begin
        state_q <= S_IDLE;
      end else if (tick_i) begin
        if (state_q != S_IDLE) begin
          if (frm_q != '1) frm_q <= frm_nx;
          ovr_pt_o <= (frm_nx == FRM_W'(OVR_TICK));
        end
        case (state_q)
          S_IDLE: if (!rx_i) begin
            state_q   <= S_START;
            ph_q      <= PH_W'(1);
            frm_q     <= FRM_W'(1);
            len_q     <= len_sel_i;
            par_en_q  <= par_sel_i[1];
            par_odd_q <= par_sel_i[0];
            stop2_q   <= stop2_i;
          end
          S_START: begin
            ph_q <= ph_nx;
            if (ph_nx == PH_W'(HALF)) begin
              if (rx_i) state_q <= S_IDLE;  // glitch: not a start bit
              else begin
                state_q <= S_DATA;
                ph_q    <= '0;
                bit_q   <= '0;
                sh_q    <= '0;
              end
            end
          end
          S_DATA: begin
            ph_q <= ph_nx;
            if (mid) begin
              ph_q  <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q + 1'b1 == len_w) state_q <= par_en_q ? S_PAR : S_STOP1;
            end
          end
          S_PAR: begin
            ph_q <= ph_nx;
            if (mid) begin
              ph_q      <= '0;
              par_bit_q <= rx_i;
              state_q   <= S_STOP1;
            end
          end
          S_STOP1: begin
            ph_q <= ph_nx;
            if (mid) begin
              ph_q   <= '0;
              ferr_q <= !rx_i;
              if (stop2_q) state_q <= S_STOP2;
              else begin
                state_q <= S_IDLE;
                done_o  <= 1'b1;
              end
            end
          end
          S_STOP2: begin
            ph_q <= ph_nx;
            if (mid) begin
              ph_q    <= '0;
              state_q <= S_IDLE;
              done_o  <= 1'b1;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // LSB arrives first and ends up lowest once shifted right by the unused width
  assign word_o    = sh_q >> (4'(DATA_W) - len_w);
  assign par_err_o = par_en_q & (^word_o ^ par_bit_q ^ par_odd_q);
  assign frm_err_o = ferr_q;
  assign busy_o    = (state_q != S_IDLE);
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              ovr_pt_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              overrun_o,
  output logic              irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      full_o    <= 1'b0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      irq_o <= load_i;
      if (load_i) begin
        data_o    <= word_i;  // overwrites on overrun
        full_o    <= 1'b1;
        par_err_o <= par_err_i;
        frm_err_o <= frm_err_i;
      end else if (rd_i) begin
        full_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          overrun_o <= 1'b0;
    else if (ovr_pt_i && full_o && !rd_i) overrun_o <= 1'b1;
    else if (ovr_clr_i)                   overrun_o <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_ovr.sv
module uart_rx_ovr #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              rx_en_i,
  input  logic              tick_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_sel_i,
  input  logic              stop2_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              overrun_o,
  output logic              irq_o
);
  logic              rx_s, done, ovr_pt, busy, w_perr, w_ferr;
  logic [DATA_W-1:0] word;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(rx_en_i), .tick_i(tick_i), .rx_i(rx_s),
    .len_sel_i(len_sel_i), .par_sel_i(par_sel_i), .stop2_i(stop2_i),
    .done_o(done), .ovr_pt_o(ovr_pt), .busy_o(busy), .word_o(word),
    .par_err_o(w_perr), .frm_err_o(w_ferr)
  );

  uart_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(done), .word_i(word),
    .par_err_i(w_perr), .frm_err_i(w_ferr), .ovr_pt_i(ovr_pt),
    .rd_i(rd_i), .ovr_clr_i(ovr_clr_i), .data_o(rd_data_o), .full_o(buf_full_o),
    .par_err_o(par_err_o), .frm_err_o(frm_err_o), .overrun_o(overrun_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/uart_rx_ovr_chk.sv
module uart_rx_ovr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic rd_i,
  input logic ovr_clr_i,
  input logic irq_o,
  input logic buf_full_o,
  input logic overrun_o,
  input logic done_i,
  input logic busy_i
);
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> buf_full_o);
  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !buf_full_o);
  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> buf_full_o);
  assert_ovr_needs_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(buf_full_o));
  assert_ovr_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);
  assert_disable_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !busy_i);
endmodule

bind uart_rx_ovr uart_rx_ovr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .rd_i(rd_i),
  .ovr_clr_i(ovr_clr_i), .irq_o(irq_o), .buf_full_o(buf_full_o),
  .overrun_o(overrun_o), .done_i(done), .busy_i(busy)
);

// File: tb/uart_rx_ovr_tb.sv
module uart_rx_ovr_tb;
  localparam int TDIV = 4;
  localparam int BIT  = 16 * TDIV;
  localparam int NV   = 8;
  // {len[1:0], par[1:0], stop2, bad_par, bad_stop, word[8:0]}
  localparam logic [15:0] VECS [NV] = '{
    {2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 9'h0A5},
    {2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 9'h05A},
    {2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 9'h1C3},
    {2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 9'h0F0},
    {2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 9'h033},
    {2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 9'h0FF},
    {2'b11, 2'b01, 1'b1, 1'b0, 1'b1, 9'h155},
    {2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 9'h1FF}
  };

  logic clk = 0, rst_n = 0, rx = 1, rx_en = 1, tick = 0, stop2 = 0, rd = 0, clr = 0;
  logic [1:0] len_sel = 2'b01, par_sel = 2'b00;
  logic [8:0] rd_data;
  logic full, perr, ferr, ovr, irq;
  int errors = 0, checks = 0, irq_cnt = 0, tcnt = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV - 1);
    if (irq) irq_cnt <= irq_cnt + 1;
  end

  uart_rx_ovr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .rx_en_i(rx_en), .tick_i(tick),
    .len_sel_i(len_sel), .par_sel_i(par_sel), .stop2_i(stop2), .rd_i(rd),
    .ovr_clr_i(clr), .rd_data_o(rd_data), .buf_full_o(full), .par_err_o(perr),
    .frm_err_o(ferr), .overrun_o(ovr), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int idx, input int rd_at);
    rx = v;
    if (idx == rd_at) begin
      rd = 1; @(negedge clk); rd = 0;
      repeat (BIT - 1) @(negedge clk);
    end else repeat (BIT) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] l, input logic [1:0] p, input logic s2,
                      input logic [8:0] w, input logic bp, input logic bs, input int rd_at);
    int n = (l == 2'b00) ? 7 : (l == 2'b01) ? 8 : 9;
    int idx = 0;
    logic pb = 1'b0;
    len_sel = l; par_sel = p; stop2 = s2;
    drive_bit(1'b0, idx++, rd_at);
    for (int i = 0; i < n; i++) begin
      pb ^= w[i];
      drive_bit(w[i], idx++, rd_at);
    end
    if (p[1]) drive_bit(pb ^ p[0] ^ bp, idx++, rd_at);
    if (bs) begin  // low long enough to cover the sample point only
      rx = 0; repeat (BIT / 2 + 2 * TDIV) @(negedge clk);
      rx = 1; repeat (BIT / 2 - 2 * TDIV) @(negedge clk);
      idx++;
    end else drive_bit(1'b1, idx++, rd_at);
    if (s2) drive_bit(1'b1, idx++, rd_at);
    rx = 1; repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd = 1; @(negedge clk); rd = 0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    int n;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 data", rd_data, 0); chk("R1 full", full, 0); chk("R1 perr", perr, 0);
    chk("R1 ferr", ferr, 0);    chk("R1 ovr", ovr, 0);   chk("R1 irq", irq, 0);
    rst_n = 1;
    repeat (3 * BIT) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] e = VECS[v];
      base = irq_cnt;
      send(e[15:14], e[13:12], e[11], e[8:0], e[10], e[9], -1);
      n = (e[15:14] == 2'b00) ? 7 : (e[15:14] == 2'b01) ? 8 : 9;
      chk("R7 irq once", irq_cnt - base, 1);
      chk("R2 data", rd_data, int'(e[8:0] & ((9'h1 << n) - 9'h1)));
      chk("R3 parity", perr, int'(e[13] & e[10]));
      chk("R4 framing", ferr, int'(e[9]));
      chk("R7 full", full, 1);
      pulse_rd();
      chk("R8 read clears", full, 0);
    end

    // R5 glitches shorter than half a bit are rejected
    base = irq_cnt;
    rx = 0; repeat (2 * TDIV) @(negedge clk); rx = 1; repeat (2 * BIT) @(negedge clk);
    rx = 0; repeat (5 * TDIV) @(negedge clk); rx = 1; repeat (2 * BIT) @(negedge clk);
    chk("R5 no word", irq_cnt - base, 0);
    chk("R5 no full", full, 0);

    // R6 disabled receiver, then abort mid-frame, then recovery
    rx_en = 0;
    send(2'b01, 2'b00, 1'b0, 9'h03C, 1'b0, 1'b0, -1);
    chk("R6 disabled", irq_cnt - base, 0);
    rx_en = 1;
    fork
      send(2'b01, 2'b00, 1'b0, 9'h0C3, 1'b0, 1'b0, -1);
      begin repeat (4 * BIT) @(negedge clk); rx_en = 0; end
    join
    chk("R6 abort", irq_cnt - base, 0);
    rx_en = 1;
    send(2'b01, 2'b00, 1'b0, 9'h066, 1'b0, 1'b0, -1);
    chk("R6 recover", rd_data, 'h066);
    pulse_rd();

    // R9 overrun and overwrite
    send(2'b01, 2'b00, 1'b0, 9'h011, 1'b0, 1'b0, -1);
    chk("R9 no ovr yet", ovr, 0);
    send(2'b01, 2'b00, 1'b0, 9'h022, 1'b0, 1'b0, -1);
    chk("R9 ovr set", ovr, 1);
    chk("R9 overwrite", rd_data, 'h022);
    pulse_rd();
    chk("R10 read keeps ovr", ovr, 1);
    clr = 1; @(negedge clk); clr = 0; @(negedge clk);
    chk("R10 clear", ovr, 0);

    // R9 boundary: read at 6 bit times avoids overrun, at 7 does not
    send(2'b01, 2'b00, 1'b0, 9'h033, 1'b0, 1'b0, -1);
    send(2'b01, 2'b00, 1'b0, 9'h044, 1'b0, 1'b0, 6);
    chk("R9 early read", ovr, 0);
    chk("R9 early data", rd_data, 'h044);
    send(2'b01, 2'b00, 1'b0, 9'h055, 1'b0, 1'b0, 7);
    chk("R9 late read", ovr, 1);
    chk("R9 late data", rd_data, 'h055);

    // R1 reset mid-run
    rst_n = 0; @(negedge clk);
    chk("R1 reset ovr", ovr, 0); chk("R1 reset full", full, 0);
    chk("R1 reset data", rd_data, 0);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule